// File: doc/BRIEF.md
# Segmented Paged Memory Translator

This block sits between an 8-bit-bus processor with a 20-bit logical address and its memory and I/O space. Each access is translated in two steps. A task number, one mode bit and four upper address bits select an entry in a segment table. That entry, combined with four middle address bits, selects an entry in a page table. The page entry supplies a 10-bit physical frame, which is joined to the 11-bit page offset to form a 21-bit physical address. The page entry also carries a write-protect flag and a not-present flag. The translated address is then steered either to the memory side or to the I/O side.

The processor function code and a "magic" flag in the task register together set an internal mode. In one mode, the upper half of the logical space opens a supervisor window. That window holds the task register, the cause input, and byte views of the segment and page entries. The entries are located through the same translation path that normal accesses use, so software edits the live tables in place. While the boot flag is clear, reads in the lowest 128 KB of logical space go to a 16 KB boot ROM instead of being translated.

Tables are read combinationally within a bus cycle. A table or task write takes effect at the clock edge where its write strobe is high.

Top module: `xlat_mmu`

## Requirements
- R1: After reset the task register is zero, which gives task 0, boot window enabled and magic clear. A write to the task register stores the bitwise complement of the data byte. Bits 3:0 hold the task number, bit 6 the boot-disable flag and bit 7 the magic flag.
- R2: The mode bit is (magic OR fc[0]) AND NOT fc[2]. When both the mode bit and address bit 19 are clear, task 0 is used whatever the task register holds.
- R3: The segment entry is selected by {task, s, A18:A15}, where s = A19 AND (A8 OR mode).
- R4: The page entry is selected by {segment entry bits 5:0, A14:A11}. physAddr is {frame, A10:A0}. writeProt and nonPresent show the selected entry's flags.
- R5: A read or write that is neither a supervisor-window access nor a boot-ROM read raises memSel when physAddr < 0x1FE000 and ioSel otherwise. At most one of memSel, ioSel and romSel is high at a time.
- R6: A read with the boot flag enabled and A19:A17 = 000 raises romSel and returns romData on rdData. romAddr is A13:A0. Writes never select the ROM.
- R7: An access is a supervisor-window access when A19 is set, the mode bit is clear and fc[1] is clear. In that window:
  - A2:A1 = 00 selects the page entry.
  - A2:A0 = 011 selects the segment entry.
  - A2:A0 = 111 reads causeIn.
  - A2:A0 = 101 writes the task register.
- R8: A page-entry access with A0 = 1 reads or writes frame bits 7:0. A write with A0 = 0 stores data bit 7 into not-present, data bit 6 into write-protect and data bits 1:0 into frame bits 9:8. A read with A0 = 0 returns {not-present, write-protect, frame[9] repeated four times, frame[9:8]}.
- R9: A segment read returns NOT magic in bit 7 and the 7 stored bits below it. A segment write stores data bits 6:0 only.
- R10: rdData is zero for reads of other supervisor-window locations, for translated reads and when no read is active.
- R11: A table write is visible to the combinational translation in the cycle after its strobe edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpuAddr | input | 20 | Logical address |
| fc | input | 3 | Processor function code |
| rdEn | input | 1 | Read access this cycle |
| wrEn | input | 1 | Write access this cycle |
| wrData | input | 8 | Write data byte |
| causeIn | input | 8 | Cause byte returned by the supervisor window |
| romData | input | 8 | Boot ROM data |
| physAddr | output | 21 | Translated physical address |
| writeProt | output | 1 | Write-protect flag of the selected page entry |
| nonPresent | output | 1 | Not-present flag of the selected page entry |
| memSel | output | 1 | Access routed to memory |
| ioSel | output | 1 | Access routed to I/O |
| romSel | output | 1 | Boot ROM read |
| romAddr | output | 14 | Boot ROM address |
| rdData | output | 8 | Register or ROM read data |

## Verification
The assertions assume the processor never raises rdEn and wrEn in the same cycle. They also assume the address, function code and data stay stable from the falling edge to the next rising edge. The bench drives every access on the falling edge and raises at most one strobe per access, so it stays within these limits.

Because the tables are not cleared by reset, the reference model records only entries it has fully written. It skips translation checks that depend on an entry it has not written. It also writes the low page byte before the high byte, so every entry it checks is completely defined.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  parameter int TASK_W     = 4;
  parameter int SEG_SEL_W  = 4;
  parameter int PAGE_SEL_W = 4;
  parameter int OFFSET_W   = 11;
  parameter int FRAME_W    = 10;
  parameter int SEG_PTR_W  = 6;
  parameter int SEG_DATA_W = 7;
  parameter int ROM_AW     = 14;
  parameter int BYTE_W     = 8;

  localparam int LA_W       = OFFSET_W + PAGE_SEL_W + SEG_SEL_W + 1;
  localparam int PHYS_W     = FRAME_W + OFFSET_W;
  localparam int SEG_IDX_W  = TASK_W + 1 + SEG_SEL_W;
  localparam int PAGE_IDX_W = SEG_PTR_W + PAGE_SEL_W;
  localparam int SEG_DEPTH  = 1 << SEG_IDX_W;
  localparam int PAGE_DEPTH = 1 << PAGE_IDX_W;
  localparam int SEG_LSB    = OFFSET_W + PAGE_SEL_W;

  typedef enum logic [2:0] {
    RD_NONE, RD_ROM, RD_PAGE_LO, RD_PAGE_HI, RD_SEG, RD_CAUSE
  } rdSrc_e;

  typedef struct packed {
    logic   segWr;
    logic   pageWrLo;
    logic   pageWrHi;
    logic   busAccess;
    rdSrc_e rdSrc;
  } xlatStrobe_t;

  typedef struct packed {
    logic               absent;
    logic               wProt;
    logic [FRAME_W-1:0] frame;
  } pageEnt_t;
endpackage

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        addrTop,
  input  logic              addrA8,
  input  logic [2:0]        addrLow,
  input  logic [2:0]        fc,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [BYTE_W-1:0] wrData,
  output xlatStrobe_t       strb,
  output logic [TASK_W-1:0] effTask,
  output logic              segHiSel,
  output logic              magic
);
  logic [BYTE_W-1:0] taskReg;
  logic modeBit, supWin, romWin, taskWr;
  logic pageHit, segHit, causeHit, taskHit;

  assign magic    = taskReg[7];
  assign modeBit  = (taskReg[7] | fc[0]) & ~fc[2];
  assign supWin   = addrTop[2] & ~modeBit & ~fc[1];
  assign romWin   = rdEn & ~taskReg[6] & (addrTop == 3'b000);
  assign effTask  = (modeBit | addrTop[2]) ? taskReg[TASK_W-1:0] : '0;
  assign segHiSel = addrTop[2] & (addrA8 | modeBit);

  assign pageHit  = (addrLow[2:1] == 2'b00);
  assign segHit   = (addrLow == 3'b011);
  assign causeHit = (addrLow == 3'b111);
  assign taskHit  = (addrLow == 3'b101);
  assign taskWr   = wrEn & supWin & taskHit;

  always_comb begin
    strb           = '0;
    strb.segWr     = wrEn & supWin & segHit;
    strb.pageWrLo  = wrEn & supWin & pageHit & addrLow[0];
    strb.pageWrHi  = wrEn & supWin & pageHit & ~addrLow[0];
    strb.busAccess = (rdEn | wrEn) & ~supWin & ~romWin;
    strb.rdSrc     = RD_NONE;
    if (romWin)                    strb.rdSrc = RD_ROM;
    else if (rdEn && supWin) begin
      if (pageHit)                 strb.rdSrc = addrLow[0] ? RD_PAGE_LO : RD_PAGE_HI;
      else if (segHit)             strb.rdSrc = RD_SEG;
      else if (causeHit)           strb.rdSrc = RD_CAUSE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      taskReg <= '0;
    else if (taskWr) taskReg <= ~wrData;
  end

  // R1
  taskLatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && addrTop[2] && !modeBit && !fc[1] && addrLow == 3'b101) |=> (taskReg == ~$past(wrData)));

  // R2
  forcedTask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!addrTop[2] && !fc[0] && !magic) |-> (effTask == '0));

  // R7
  supNoBus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.segWr || strb.pageWrLo || strb.pageWrHi) |-> !strb.busAccess);

  // R6
  romOnlyRead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && !rdEn) |-> (strb.rdSrc == RD_NONE));
endmodule

// File: rtl/xlat_dp.sv
module xlat_dp
  import xlat_pkg::*;
#(
  parameter logic [PHYS_W-1:0] IO_BASE = 21'h1FE000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LA_W-2:0]   addrLo,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [BYTE_W-1:0] causeIn,
  input  logic [BYTE_W-1:0] romData,
  input  xlatStrobe_t       strb,
  input  logic [TASK_W-1:0] effTask,
  input  logic              segHiSel,
  input  logic              magic,
  output logic [PHYS_W-1:0] physAddr,
  output logic              writeProt,
  output logic              nonPresent,
  output logic              memSel,
  output logic              ioSel,
  output logic              romSel,
  output logic [ROM_AW-1:0] romAddr,
  output logic [BYTE_W-1:0] rdData
);
  logic [SEG_DATA_W-1:0] segTbl  [SEG_DEPTH];
  pageEnt_t              pageTbl [PAGE_DEPTH];

  logic [SEG_IDX_W-1:0]  segIdx;
  logic [PAGE_IDX_W-1:0] pageIdx;
  logic [SEG_DATA_W-1:0] segEntry;
  pageEnt_t              pageEntry;
  logic [BYTE_W-1:0]     pageHiByte;

  assign segIdx    = {effTask, segHiSel, addrLo[SEG_LSB +: SEG_SEL_W]};
  assign segEntry  = segTbl[segIdx];
  assign pageIdx   = {segEntry[SEG_PTR_W-1:0], addrLo[OFFSET_W +: PAGE_SEL_W]};
  assign pageEntry = pageTbl[pageIdx];

  assign physAddr   = {pageEntry.frame, addrLo[OFFSET_W-1:0]};
  assign writeProt  = pageEntry.wProt;
  assign nonPresent = pageEntry.absent;
  assign memSel     = strb.busAccess & (physAddr <  IO_BASE);
  assign ioSel      = strb.busAccess & (physAddr >= IO_BASE);
  assign romSel     = (strb.rdSrc == RD_ROM);
  assign romAddr    = addrLo[ROM_AW-1:0];

  assign pageHiByte = {pageEntry.absent, pageEntry.wProt,
                       {4{pageEntry.frame[FRAME_W-1]}}, pageEntry.frame[FRAME_W-1 -: 2]};

  always_comb begin
    unique case (strb.rdSrc)
      RD_ROM:     rdData = romData;
      RD_PAGE_LO: rdData = pageEntry.frame[BYTE_W-1:0];
      RD_PAGE_HI: rdData = pageHiByte;
      RD_SEG:     rdData = {~magic, segEntry};
      RD_CAUSE:   rdData = causeIn;
      default:    rdData = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (strb.segWr) segTbl[segIdx] <= wrData[SEG_DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (strb.pageWrLo) pageTbl[pageIdx].frame[BYTE_W-1:0] <= wrData;
    if (strb.pageWrHi) begin
      pageTbl[pageIdx].absent                 <= wrData[7];
      pageTbl[pageIdx].wProt                  <= wrData[6];
      pageTbl[pageIdx].frame[FRAME_W-1 -: 2]  <= wrData[1:0];
    end
  end

  // R5
  routeOneHot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({memSel, ioSel, romSel}));

  // R4
  offsetPass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (memSel || ioSel) |-> (physAddr[OFFSET_W-1:0] == addrLo[OFFSET_W-1:0]));

  // R5
  ioRange_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ioSel |-> (physAddr >= IO_BASE));

  // R11
  segCommit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.segWr |=> (segTbl[$past(segIdx)] == $past(wrData[SEG_DATA_W-1:0])));

  // R8
  pageLoCommit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.pageWrLo |=> (pageTbl[$past(pageIdx)].frame[BYTE_W-1:0] == $past(wrData)));
endmodule

// File: rtl/xlat_mmu.sv
module xlat_mmu
  import xlat_pkg::*;
#(
  parameter logic [PHYS_W-1:0] IO_BASE = 21'h1FE000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LA_W-1:0]   cpuAddr,
  input  logic [2:0]        fc,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [BYTE_W-1:0] causeIn,
  input  logic [BYTE_W-1:0] romData,
  output logic [PHYS_W-1:0] physAddr,
  output logic              writeProt,
  output logic              nonPresent,
  output logic              memSel,
  output logic              ioSel,
  output logic              romSel,
  output logic [ROM_AW-1:0] romAddr,
  output logic [BYTE_W-1:0] rdData
);
  xlatStrobe_t       strb;
  logic [TASK_W-1:0] effTask;
  logic              segHiSel, magic;

  xlat_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .addrTop  (cpuAddr[LA_W-1 -: 3]),
    .addrA8   (cpuAddr[8]),
    .addrLow  (cpuAddr[2:0]),
    .fc       (fc),
    .rdEn     (rdEn),
    .wrEn     (wrEn),
    .wrData   (wrData),
    .strb     (strb),
    .effTask  (effTask),
    .segHiSel (segHiSel),
    .magic    (magic)
  );

  xlat_dp #(.IO_BASE(IO_BASE)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .addrLo     (cpuAddr[LA_W-2:0]),
    .wrData     (wrData),
    .causeIn    (causeIn),
    .romData    (romData),
    .strb       (strb),
    .effTask    (effTask),
    .segHiSel   (segHiSel),
    .magic      (magic),
    .physAddr   (physAddr),
    .writeProt  (writeProt),
    .nonPresent (nonPresent),
    .memSel     (memSel),
    .ioSel      (ioSel),
    .romSel     (romSel),
    .romAddr    (romAddr),
    .rdData     (rdData)
  );
endmodule

// File: tb/xlat_mmu_bench.sv
`timescale 1ns/1ps
module xlat_mmu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] cpuAddr = '0;
  logic [2:0]  fc = 3'b101;
  logic        rdEn = 1'b0, wrEn = 1'b0;
  logic [7:0]  wrData = '0, causeIn = '0, romData = '0;
  logic [20:0] physAddr;
  logic        writeProt, nonPresent, memSel, ioSel, romSel;
  logic [13:0] romAddr;
  logic [7:0]  rdData;

  localparam logic [2:0] SUP = 3'b101, USR = 3'b001, PRG = 3'b010, F0 = 3'b000;

  always #2.5 clk = ~clk;

  xlat_mmu u_xlat_mmu (.*);

  int nVec = 0, nBad = 0;
  logic [7:0] mTask = '0;
  logic [6:0] mSeg [int];
  logic [11:0] mPage [int];
  logic [7:0] mLo [int];

  task automatic chk(string req, string what, longint act, longint exp);
    nVec++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic access(string tag, logic [19:0] a, logic [2:0] f, logic rd, logic wr, logic [7:0] d);
    logic ifc2, s19, sup, rom, segK, pgK, pHit;
    logic [3:0] tsk;
    int si, pi;
    logic [11:0] pe;
    logic [20:0] pa;
    logic [7:0] expRd;
    logic expRdK;
    @(negedge clk);
    cpuAddr = a; fc = f; rdEn = rd; wrEn = wr; wrData = d;
    romData = a[7:0] ^ 8'h5A; causeIn = a[15:8] ^ 8'hC3;
    #1;
    ifc2 = (mTask[7] | f[0]) & ~f[2];
    tsk  = (ifc2 | a[19]) ? mTask[3:0] : 4'd0;
    s19  = a[19] & (a[8] | ifc2);
    si   = int'({tsk, s19, a[18:15]});
    sup  = a[19] & ~ifc2 & ~f[1];
    rom  = rd & ~mTask[6] & (a[19:17] == 3'b000);
    segK = mSeg.exists(si);
    pi   = segK ? int'({mSeg[si][5:0], a[14:11]}) : 0;
    pgK  = segK && mPage.exists(pi);
    pe   = pgK ? mPage[pi] : '0;
    pa   = {pe[9:0], a[10:0]};
    pHit = (a[2:1] == 2'b00);
    expRd = 8'h00; expRdK = 1'b1;
    if (rd && rom) expRd = romData;
    else if (rd && sup) begin
      if (pHit) begin
        expRdK = pgK;
        expRd  = a[0] ? pe[7:0] : {pe[11], pe[10], {4{pe[9]}}, pe[9:8]};
      end else if (a[2:0] == 3'b011) begin
        expRdK = segK; expRd = segK ? {~mTask[7], mSeg[si]} : 8'h00;
      end else if (a[2:0] == 3'b111) expRd = causeIn;
    end
    // R6 boot window selection and ROM address
    chk("R6", "romSel", romSel, rom);
    chk("R6", "romAddr", romAddr, a[13:0]);
    if (expRdK) chk(tag, "rdData", rdData, expRd);
    if (pgK) begin
      chk(tag, "physAddr", physAddr, pa);
      chk("R4", "writeProt", writeProt, pe[10]);
      chk("R4", "nonPresent", nonPresent, pe[11]);
      // R5 routing against the 0x1FE000 boundary
      chk("R5", "memSel", memSel, (rd | wr) & ~sup & ~rom & (pa <  21'h1FE000));
      chk("R5", "ioSel",  ioSel,  (rd | wr) & ~sup & ~rom & (pa >= 21'h1FE000));
    end
    if (wr && sup) begin
      if (a[2:0] == 3'b101) mTask = ~d;
      else if (a[2:0] == 3'b011) mSeg[si] = d[6:0];
      else if (pHit && segK) begin
        if (a[0]) begin
          if (mPage.exists(pi)) mPage[pi][7:0] = d; else mLo[pi] = d;
        end else begin
          if (mPage.exists(pi)) mPage[pi][11:8] = {d[7], d[6], d[1:0]};
          else if (mLo.exists(pi)) mPage[pi] = {d[7], d[6], d[1:0], mLo[pi]};
        end
      end
    end
    @(posedge clk);
  endtask

  function automatic logic [19:0] supA(logic a8, logic [3:0] seg, logic [3:0] pg, logic [2:0] lo);
    return {1'b1, seg, pg, 2'b00, a8, 5'b00000, lo};
  endfunction

  task automatic segW(logic a8, logic [3:0] seg, logic [7:0] d);
    access("R9", supA(a8, seg, 4'd0, 3'b011), SUP, 1'b0, 1'b1, d);
  endtask

  task automatic pageW(logic a8, logic [3:0] seg, logic [3:0] pg, logic [15:0] e);
    access("R8", supA(a8, seg, pg, 3'b001), SUP, 1'b0, 1'b1, e[7:0]);
    access("R8", supA(a8, seg, pg, 3'b000), SUP, 1'b0, 1'b1, {e[15:14], 4'b0000, e[9:8]});
  endtask

  task automatic taskW(logic [7:0] d);
    access("R1", 20'h80005, SUP, 1'b0, 1'b1, d);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1 reset state: boot window open, task 0
    access("R1", 20'h01234, SUP, 1'b1, 1'b0, 8'h00);
    access("R6", 20'h1FFFF, USR, 1'b1, 1'b0, 8'h00);
    access("R6", 20'h00010, USR, 1'b0, 1'b1, 8'h77);
    // task 0 tables
    segW(1'b0, 4'd2, 8'h11);
    pageW(1'b0, 4'd2, 4'd3, 16'h4123);
    access("R2", {1'b0, 4'd2, 4'd3, 11'h2AB}, F0, 1'b1, 1'b0, 8'h00);
    // R1 complement: 0xBA -> task 5, boot off, magic 0
    taskW(8'hBA);
    access("R1", 20'h00010, USR, 1'b1, 1'b0, 8'h00);
    segW(1'b0, 4'd2, 8'hAA);
    pageW(1'b0, 4'd2, 4'd3, 16'h83FC);
    pageW(1'b0, 4'd2, 4'd4, 16'h03FB);
    pageW(1'b0, 4'd2, 4'd5, 16'h0000);
    // R2 mode bit selects task 5, forced task 0 otherwise
    access("R2", {1'b0, 4'd2, 4'd3, 11'h000}, USR, 1'b1, 1'b0, 8'h00);
    access("R2", {1'b0, 4'd2, 4'd3, 11'h000}, F0,  1'b1, 1'b0, 8'h00);
    access("R5", {1'b0, 4'd2, 4'd4, 11'h7FF}, USR, 1'b1, 1'b0, 8'h00);
    access("R5", {1'b0, 4'd2, 4'd3, 11'h001}, USR, 1'b0, 1'b1, 8'h33);
    // R3 upper half with mode bit forces the high segment bank
    segW(1'b1, 4'd6, 8'h05);
    pageW(1'b1, 4'd6, 4'd1, 16'h0555);
    access("R3", {1'b1, 4'd6, 4'd1, 11'h0E0}, USR, 1'b1, 1'b0, 8'h00);
    access("R3", {1'b1, 4'd6, 4'd1, 11'h1E0}, PRG, 1'b1, 1'b0, 8'h00);
    access("R7", {1'b1, 4'd6, 4'd1, 11'h000}, PRG, 1'b1, 1'b0, 8'h00);
    // R9 / R8 readback
    access("R9", supA(1'b0, 4'd2, 4'd0, 3'b011), SUP, 1'b1, 1'b0, 8'h00);
    access("R8", supA(1'b0, 4'd2, 4'd3, 3'b001), SUP, 1'b1, 1'b0, 8'h00);
    access("R8", supA(1'b0, 4'd2, 4'd3, 3'b000), SUP, 1'b1, 1'b0, 8'h00);
    access("R8", supA(1'b0, 4'd2, 4'd5, 3'b000), SUP, 1'b0, 1'b1, 8'h3C);
    access("R8", supA(1'b0, 4'd2, 4'd5, 3'b000), SUP, 1'b1, 1'b0, 8'h00);
    access("R8", supA(1'b0, 4'd2, 4'd5, 3'b110), SUP, 1'b1, 1'b0, 8'h00);
    segW(1'b0, 4'd7, 8'hFF);
    access("R9", supA(1'b0, 4'd7, 4'd0, 3'b011), SUP, 1'b1, 1'b0, 8'h00);
    // R10 cause and unused locations
    access("R10", 20'h80007, SUP, 1'b1, 1'b0, 8'h00);
    access("R10", 20'h80005, SUP, 1'b1, 1'b0, 8'h00);
    access("R10", 20'h80002, SUP, 1'b1, 1'b0, 8'h00);
    // R11 page edit visible next cycle
    access("R11", supA(1'b0, 4'd2, 4'd4, 3'b001), SUP, 1'b0, 1'b1, 8'hFC);
    access("R11", {1'b0, 4'd2, 4'd4, 11'h7FF}, USR, 1'b1, 1'b0, 8'h00);
    // magic set (data 0x3A -> reg 0xC5): fc 000 leaves the supervisor window
    taskW(8'h3A);
    access("R7", {1'b1, 4'd6, 4'd1, 11'h003}, F0, 1'b1, 1'b0, 8'h00);
    access("R9", supA(1'b0, 4'd2, 4'd0, 3'b011), SUP, 1'b1, 1'b0, 8'h00);
    access("R2", {1'b0, 4'd2, 4'd3, 11'h100}, F0, 1'b1, 1'b0, 8'h00);
    for (int i = 0; i < 24; i++)
      access("R4", {i[0], 4'd2, 4'(3 + i % 3), 11'(i * 83)}, USR, i[1], ~i[1], 8'(i));
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    #1000000;
    nVec++; nBad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule